// File: doc/BRIEF.md
# Background Register Context Transfer Engine

This block moves a thread's register context between a core and a context memory. A context is seventeen 32-bit words: sixteen general registers and the program counter. A save command takes a snapshot of the core's live context in the cycle it is accepted. The engine then streams that snapshot into memory beat by beat while the core keeps executing. A restore command fetches a stored context into a private staging buffer. The restored context reaches the core in one step, only in the cycle that `done` is raised, so a thread switch costs the core just that final hand-over.

The memory bus width is a parameter. The number of beats per context is B = ceil(17*32 / BUS_W): 17 beats on a 32-bit bus, 9 on a 64-bit bus, and 1 on a 544-bit bus. Each thread owns B consecutive memory words starting at `tid * B`. The memory sits outside the block and is any synchronous RAM with a one-cycle read latency, on chip or off chip behind a suitable port. The block accepts one command at a time. A command that arrives while it is busy is dropped and flagged.

Top module: `ctx_xfer_engine`

## Requirements
- R1: After reset, `busy`, `done`, `refused`, `mem_en` and `mem_we` are low and `ctx_out` is all zeros.
- R2: A context occupies B = ceil(17*32/BUS_W) memory words. Beat k of thread t is at address t*B + k, and beats are issued in ascending k on consecutive cycles.
- R3: Words leave in the order R15, R14, ..., R0, then PC. Slot s of that sequence goes in beat s/N (N = BUS_W/32), in lane s mod N, and lane 0 occupies the most significant 32 bits of the beat. Lanes past the last slot are zero. In `ctx_in` and `ctx_out`, bits [32i+31:32i] hold Ri for i < 16 and the PC for i = 16.
- R4: A save command (`cmd_save`=1) accepted at a clock edge stores the value of `ctx_in` sampled at that edge. Later changes to `ctx_in` do not affect what is stored. Its B writes happen in the B cycles after acceptance, and `done` is high in the next cycle, which is B cycles after acceptance.
- R5: A restore command (`cmd_save`=0) reads its B beats in the B cycles after acceptance. `done` is high B+1 cycles after acceptance, and `ctx_out` carries the stored context from that same cycle.
- R6: `ctx_out` changes only in a cycle where `done` is high at the end of a restore. A save leaves it unchanged.
- R7: `busy` is high from the cycle after acceptance until `done`. It is low while `done` is high, `done` lasts one cycle, and a command presented in the `done` cycle is accepted.
- R8: A command presented while `busy` is high is ignored: no memory access, no change to stored data or `ctx_out`. `refused` is high for exactly the following cycle.
- R9: `mem_en` is high only while beats are being issued, and `mem_we` is high only for save beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_save | input | 1 | 1 = save context, 0 = restore context |
| cmd_tid | input | TID_W | Thread number of the command |
| ctx_in | input | 544 | Live core context, sampled on save acceptance |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| refused | output | 1 | Previous cycle's command was dropped |
| ctx_out | output | 544 | Context handed to the core on restore completion |
| mem_en | output | 1 | Context memory access enable |
| mem_we | output | 1 | Context memory write enable |
| mem_addr | output | ADDR_W | Context memory word address |
| mem_wdata | output | BUS_W | Context memory write data |
| mem_rdata | input | BUS_W | Context memory read data, one cycle after a read |

## Verification
The assertions take three things for granted. `cmd_tid` stays below THREADS, so addresses stay within the thread area. The memory returns, one cycle after a read, the word last written at that address. Only previously saved threads are restored. The stimulus draws thread numbers only from the configured range and restores only threads it has saved before. Its memory model has exactly one cycle of read latency. Commands that collide with a busy engine are sent deliberately and in a controlled way, to exercise the refusal path without breaking those assumptions.

// File: rtl/ctx_xfer_pkg.sv
package ctx_xfer_pkg;

   localparam int WORD_W    = 32;
   localparam int NUM_REGS  = 16;
   localparam int NUM_WORDS = NUM_REGS + 1;
   localparam int CTX_W     = NUM_WORDS * WORD_W;

   typedef enum logic {
      OP_RESTORE = 1'b0,
      OP_SAVE    = 1'b1
   } xfer_op_e;

   // Transfer slot s -> word index in the flat context vector.
   // Slots 0..NUM_REGS-1 walk the general registers downward; the last slot is the PC.
   function automatic int slot_word(input int s);
      if (s < NUM_REGS) return NUM_REGS - 1 - s;
      return NUM_WORDS - 1;
   endfunction

endpackage

// File: rtl/ctx_xfer_seq.sv
module ctx_xfer_seq
   import ctx_xfer_pkg::*;
#(
   parameter int BEATS = 9,
   parameter int BW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic          cmd_save,
   output logic          accept,
   output logic          busy,
   output logic          save_op,
   output logic          issue,
   output logic [BW-1:0] beat,
   output logic          cap_valid,
   output logic [BW-1:0] cap_beat,
   output logic          restore_last,
   output logic          finish,
   output logic          refused
);

   localparam int CW = $clog2(BEATS + 1);
   localparam logic [CW-1:0] CNT_END  = CW'(BEATS);
   localparam logic [CW-1:0] CNT_LAST = CW'(BEATS - 1);
   localparam logic [BW-1:0] CAP_LAST = BW'(BEATS - 1);

   logic          busy_q;
   xfer_op_e      op_q;
   logic [CW-1:0] cnt_q;
   logic          cap_q;
   logic [BW-1:0] cap_beat_q;
   logic          refused_q;
   logic          save_last;

   assign accept       = cmd_valid && !busy_q;
   assign issue        = busy_q && (cnt_q < CNT_END);
   assign beat         = cnt_q[BW-1:0];
   assign save_last    = issue && (op_q == OP_SAVE) && (cnt_q == CNT_LAST);
   assign restore_last = busy_q && (op_q == OP_RESTORE) && cap_q && (cap_beat_q == CAP_LAST);
   assign finish       = save_last || restore_last;
   assign busy         = busy_q;
   assign save_op      = (op_q == OP_SAVE);
   assign cap_valid    = cap_q;
   assign cap_beat     = cap_beat_q;
   assign refused      = refused_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         op_q       <= OP_RESTORE;
         cnt_q      <= '0;
         cap_q      <= 1'b0;
         cap_beat_q <= '0;
         refused_q  <= 1'b0;
      end else begin
         refused_q  <= cmd_valid && busy_q;
         cap_q      <= issue && (op_q == OP_RESTORE);
         cap_beat_q <= cnt_q[BW-1:0];
         if (accept) begin
            busy_q <= 1'b1;
            op_q   <= cmd_save ? OP_SAVE : OP_RESTORE;
            cnt_q  <= '0;
         end else begin
            if (finish) busy_q <= 1'b0;
            if (issue)  cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ctx_beat_pack.sv
module ctx_beat_pack
   import ctx_xfer_pkg::*;
#(
   parameter int BUS_W = 64,
   parameter int BW    = 4
) (
   input  logic [CTX_W-1:0] ctx,
   input  logic [BW-1:0]    beat,
   output logic [BUS_W-1:0] data
);

   localparam int WPB = BUS_W / WORD_W;

   for (genvar j = 0; j < WPB; j++) begin : g_lane
      logic [WORD_W-1:0] lane;
      always_comb begin
         lane = '0;
         if (int'(beat) * WPB + j < NUM_WORDS)
            lane = ctx[slot_word(int'(beat) * WPB + j) * WORD_W +: WORD_W];
      end
      assign data[BUS_W - WORD_W * (j + 1) +: WORD_W] = lane;
   end

endmodule

// File: rtl/ctx_beat_unpack.sv
module ctx_beat_unpack
   import ctx_xfer_pkg::*;
#(
   parameter int BUS_W = 64,
   parameter int BW    = 4
) (
   input  logic [CTX_W-1:0] ctx_in,
   input  logic             en,
   input  logic [BW-1:0]    beat,
   input  logic [BUS_W-1:0] data,
   output logic [CTX_W-1:0] ctx_out
);

   localparam int WPB = BUS_W / WORD_W;

   always_comb begin
      ctx_out = ctx_in;
      if (en) begin
         for (int j = 0; j < WPB; j++) begin
            if (int'(beat) * WPB + j < NUM_WORDS)
               ctx_out[slot_word(int'(beat) * WPB + j) * WORD_W +: WORD_W] =
                  data[BUS_W - WORD_W * (j + 1) +: WORD_W];
         end
      end
   end

endmodule

// File: rtl/ctx_xfer_engine.sv
module ctx_xfer_engine
   import ctx_xfer_pkg::*;
#(
   parameter int BUS_W   = 64,
   parameter int THREADS = 4,
   localparam int WPB    = BUS_W / WORD_W,
   localparam int BEATS  = (NUM_WORDS + WPB - 1) / WPB,
   localparam int DEPTH  = THREADS * BEATS,
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_save,
   input  logic [TID_W-1:0]  cmd_tid,
   input  logic [CTX_W-1:0]  ctx_in,
   output logic              busy,
   output logic              done,
   output logic              refused,
   output logic [CTX_W-1:0]  ctx_out,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BUS_W-1:0]  mem_wdata,
   input  logic [BUS_W-1:0]  mem_rdata
);

   localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

   if (BUS_W < WORD_W || (BUS_W % WORD_W) != 0) begin : g_bad_bus
      $error("BUS_W must be a positive multiple of the word width");
   end
   if (BUS_W > CTX_W) begin : g_wide_bus
      $error("BUS_W wider than one full context");
   end
   if (THREADS < 1) begin : g_bad_thr
      $error("THREADS must be at least one");
   end

   logic              accept;
   logic              save_op;
   logic              issue;
   logic [BW-1:0]     beat;
   logic              cap_valid;
   logic [BW-1:0]     cap_beat;
   logic              restore_last;
   logic              finish;
   logic [TID_W-1:0]  tid_q;
   logic [CTX_W-1:0]  stage_q;
   logic [CTX_W-1:0]  stage_nxt;
   logic [CTX_W-1:0]  ctx_out_q;
   logic              done_q;
   logic [BUS_W-1:0]  packed_beat;

   ctx_xfer_seq #(.BEATS(BEATS), .BW(BW)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_save     (cmd_save),
      .accept       (accept),
      .busy         (busy),
      .save_op      (save_op),
      .issue        (issue),
      .beat         (beat),
      .cap_valid    (cap_valid),
      .cap_beat     (cap_beat),
      .restore_last (restore_last),
      .finish       (finish),
      .refused      (refused)
   );

   ctx_beat_pack #(.BUS_W(BUS_W), .BW(BW)) u_pack (
      .ctx  (stage_q),
      .beat (beat),
      .data (packed_beat)
   );

   ctx_beat_unpack #(.BUS_W(BUS_W), .BW(BW)) u_unpack (
      .ctx_in  (stage_q),
      .en      (cap_valid),
      .beat    (cap_beat),
      .data    (mem_rdata),
      .ctx_out (stage_nxt)
   );

   if (BEATS == 1) begin : g_addr_single
      assign mem_addr = ADDR_W'(tid_q);
   end else begin : g_addr_multi
      assign mem_addr = ADDR_W'(tid_q) * ADDR_W'(BEATS) + ADDR_W'(beat);
   end

   assign mem_en    = issue;
   assign mem_we    = issue && save_op;
   assign mem_wdata = (issue && save_op) ? packed_beat : '0;
   assign done      = done_q;
   assign ctx_out   = ctx_out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tid_q     <= '0;
         stage_q   <= '0;
         ctx_out_q <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= finish;
         if (accept) tid_q <= cmd_tid;
         if (accept && cmd_save) stage_q <= ctx_in;
         else if (cap_valid)     stage_q <= stage_nxt;
         if (restore_last) ctx_out_q <= stage_nxt;
      end
   end

endmodule

// File: rtl/ctx_xfer_chk.sv
module ctx_xfer_chk #(
   parameter int CTX_W  = 544,
   parameter int ADDR_W = 6,
   parameter int DEPTH  = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              busy,
   input logic              done,
   input logic              refused,
   input logic [CTX_W-1:0]  ctx_out,
   input logic              mem_en,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr
);

   // R8
   refuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && busy |=> refused);

   // R8
   refuse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refused |-> $past(cmd_valid && busy));

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctx_out) |-> done);

   // R9
   write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_en && busy);

   // R2
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> ({1'b0, mem_addr} < (ADDR_W + 1)'(DEPTH)));

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en && $past(mem_en) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

endmodule

bind ctx_xfer_engine ctx_xfer_chk #(
   .CTX_W  (ctx_xfer_pkg::CTX_W),
   .ADDR_W (ADDR_W),
   .DEPTH  (DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .busy      (busy),
   .done      (done),
   .refused   (refused),
   .ctx_out   (ctx_out),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr)
);

// File: tb/tb_ctx_xfer_engine.sv
module tb_ctx_xfer_engine;

   localparam int BUS_W   = 64;
   localparam int THREADS = 4;
   localparam int N       = BUS_W / 32;
   localparam int B       = (17 + N - 1) / N;
   localparam int CTX_W   = 544;
   localparam int DEPTH   = THREADS * B;
   localparam int ADDR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_save = 1'b0;
   logic [TID_W-1:0]  cmd_tid = '0;
   logic [CTX_W-1:0]  ctx_in = '0;
   logic              busy, done, refused;
   logic [CTX_W-1:0]  ctx_out;
   logic              mem_en, mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [BUS_W-1:0]  mem_wdata;
   logic [BUS_W-1:0]  mem_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit run_chk = 1'b0;

   always #5 clk = ~clk;

   ctx_xfer_engine #(.BUS_W(BUS_W), .THREADS(THREADS)) dut (
      .clk, .rst_n, .cmd_valid, .cmd_save, .cmd_tid, .ctx_in,
      .busy, .done, .refused, .ctx_out,
      .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata
   );

   // Context memory: synchronous, one-cycle read latency
   logic [BUS_W-1:0] ram [DEPTH];
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) ram[mem_addr] <= mem_wdata;
         else        mem_rdata     <= ram[mem_addr];
      end
   end

   task automatic chk(input string tag, input logic [CTX_W-1:0] act, input logic [CTX_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // Beat k of a context in the specified transfer layout
   function automatic logic [BUS_W-1:0] beat_of(input logic [CTX_W-1:0] c, input int k);
      logic [31:0] seq[$];
      logic [BUS_W-1:0] d;
      for (int r = 15; r >= 0; r--) seq.push_back(c[32*r +: 32]);
      seq.push_back(c[32*16 +: 32]);
      while (seq.size() < B * N) seq.push_back(32'h0);
      d = '0;
      for (int j = 0; j < N; j++) d[BUS_W - 32*(j+1) +: 32] = seq[k*N + j];
      return d;
   endfunction

   function automatic logic [CTX_W-1:0] pattern(input int seed);
      logic [CTX_W-1:0] c;
      for (int i = 0; i < 17; i++) c[32*i +: 32] = (seed * 32'h01000193) ^ (i * 32'h00010101) ^ 32'h5A000000;
      return c;
   endfunction

   // Reference model
   bit               m_busy, m_done, m_ref, m_save, m_was;
   int               m_k, m_tid;
   logic [CTX_W-1:0] m_snap, m_ctx;
   logic [CTX_W-1:0] store [THREADS];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_ref = 0; m_k = 0; m_ctx = '0; m_save = 0; m_tid = 0;
      end else begin
         m_was = m_busy; m_done = 0; m_ref = 0;
         if (m_busy) begin
            m_k++;
            if (m_k == (m_save ? B : B + 1)) begin
               m_busy = 0; m_done = 1;
               if (m_save) store[m_tid] = m_snap;
               else        m_ctx = store[m_tid];
            end
         end
         if (cmd_valid) begin
            if (m_was) m_ref = 1;
            else begin
               m_busy = 1; m_k = 0; m_save = cmd_save; m_tid = int'(cmd_tid); m_snap = ctx_in;
            end
         end
      end
   end

   // Every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && run_chk) begin
         bit e_en;
         e_en = m_busy && (m_k < B);
         chk("R7 busy", busy, m_busy);
         chk("R7 done", done, m_done);
         chk("R8 refused", refused, m_ref);
         chk("R9 mem_en", mem_en, e_en);
         chk("R9 mem_we", mem_we, e_en && m_save);
         chk("R6 ctx_out", ctx_out, m_ctx);
         if (e_en) chk("R2 mem_addr", mem_addr, m_tid * B + m_k);
         if (e_en && m_save) chk("R3 mem_wdata", mem_wdata, beat_of(m_snap, m_k));
      end
   end

   // Caller is positioned at a falling edge
   task automatic issue_cmd(input bit save, input int tid, input logic [CTX_W-1:0] c);
      cmd_valid = 1'b1; cmd_save = save; cmd_tid = TID_W'(tid); ctx_in = c;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_done(input string tag, input int exp_lat);
      int lat = 0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      chk(tag, lat, exp_lat);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL R7 watchdog act=hung exp=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 refused", refused, 0);
      chk("R1 mem_en", mem_en, 0);
      chk("R1 mem_we", mem_we, 0);
      chk("R1 ctx_out", ctx_out, '0);
      rst_n = 1'b1;
      run_chk = 1'b1;
      @(negedge clk);

      // R4 save latency, R3 layout checked every cycle
      issue_cmd(1, 0, pattern(1));
      wait_done("R4 save latency", B);
      // R7 back-to-back: command in the done cycle
      issue_cmd(1, 1, pattern(2));
      wait_done("R4 save latency 2", B);
      @(negedge clk);

      // R4 background: ctx_in changes right after acceptance
      issue_cmd(1, THREADS - 1, pattern(3));
      ctx_in = pattern(99);
      wait_done("R4 save background", B);
      chk("R6 ctx_out after save", ctx_out, '0);
      @(negedge clk);

      // R5 restore latency and contents
      issue_cmd(0, 1, '0);
      wait_done("R5 restore latency", B + 1);
      chk("R5 restored thread 1", ctx_out, pattern(2));
      issue_cmd(0, THREADS - 1, '0);
      wait_done("R5 restore latency max tid", B + 1);
      chk("R4 snapshot kept", ctx_out, pattern(3));
      @(negedge clk);

      // R8 collision: save while a restore is running is dropped
      issue_cmd(0, 0, '0);
      @(negedge clk);
      issue_cmd(1, 0, pattern(77));
      chk("R8 refused flag", refused, 1);
      wait_done("R8 restore unaffected", B - 1);
      chk("R8 restored thread 0", ctx_out, pattern(1));
      @(negedge clk);
      issue_cmd(0, 0, '0);
      wait_done("R8 store untouched latency", B + 1);
      chk("R8 store untouched", ctx_out, pattern(1));

      // overwrite then restore
      @(negedge clk);
      issue_cmd(1, 0, pattern(5));
      wait_done("R4 overwrite", B);
      issue_cmd(0, 0, '0);
      wait_done("R5 restore overwrite", B + 1);
      chk("R5 overwritten thread 0", ctx_out, pattern(5));
      repeat (3) @(negedge clk);

      run_chk = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule